// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serializes one byte at a time onto an asynchronous serial line. The shape of each character comes from an eight-bit line-control input. That input selects the number of data bits, whether a parity bit is sent, the parity rule, and how long the stop period lasts. A separate bit of the same input pulls the line low to signal a break. The bit timing comes from a baud tick that runs at sixteen times the bit rate. The divisor that makes this tick is generated outside the block.

A producer offers a byte with `valid_i`. The block takes it on a clock edge where both `valid_i` and `ready_o` are high. At that same edge it also captures the framing settings, so a change to the line-control input during a character has no effect until the next one. The break bit is the only exception: it acts on the line at once. Bit 7 of the line-control input has no part in framing and is passed out unchanged as a status output.

Top module: `sctx_top`

## Requirements
- R1: After reset, and whenever no character is in progress, `ready_o` is 1 and `tx_o` is 1 unless break is requested.
- R2: Line-control bits [1:0] set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: A character starts with one low start bit. The data bits follow, least significant bit first. Each start, data and parity bit lasts 16 baud ticks.
- R4: When line-control bit 2 is 0, the stop period is high for 16 ticks. `ready_o` rises at the end of that period.
- R5: When line-control bit 2 is 1, the stop period is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R6: When line-control bit 3 is 1, a parity bit follows the data. With bit 5 clear, bit 4 = 1 makes the total count of ones in data plus parity even, and bit 4 = 0 makes it odd.
- R7: When bits 3 and 5 are both 1, the parity bit is fixed: it is 0 when bit 4 is 1 and 1 when bit 4 is 0.
- R8: While line-control bit 6 is 1, `tx_o` is 0, both when idle and during a character. A character in progress keeps its normal timing.
- R9: `ready_o` is 0 from the edge that accepts a byte until the stop period ends. `valid_i` has no effect during that time.
- R10: Framing is taken at acceptance. Changes to line-control bits other than bit 6 during a character do not alter that character.
- R11: `dlab_o` always equals line-control bit 7.
- R12: The character advances only on clock edges where `tick16_i` is 1. Without ticks the line and `ready_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Baud tick at 16x bit rate, one clock wide |
| lcr_i | input | 8 | Line-control byte |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Transmitter idle, byte can be taken |
| tx_o | output | 1 | Serial line output |
| dlab_o | output | 1 | Copy of line-control bit 7 |

## Verification
The properties assume that `tick16_i` is a plain level sampled on each clock edge, and that `lcr_i` bit 6 may change at any edge. For that reason the line-stability property is only claimed on cycles where the break bit does not move. The bench holds `valid_i` for exactly one accepting edge. It changes `lcr_i` only on falling clock edges, and only between acceptance and the end of the frame when it is testing R10 or R8. It holds the tick low only in the dedicated hold test, so every frame length it predicts is a whole number of ticks.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } sctx_state_e;

  typedef struct packed {
    logic [1:0] wlen;   // data bits minus 5
    logic       stop_x; // extended stop period
    logic       par_en;
    logic       par_even;
    logic       par_fix;
  } sctx_cfg_t;
endpackage

// File: rtl/sctx_cfg_dec.sv
module sctx_cfg_dec
  import sctx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  localparam int LIM_W = $clog2(2 * TICKS_PER_BIT) + 1
) (
  input  logic [7:0]       lcr_i,
  output sctx_cfg_t        cfg_o,
  output logic [LIM_W-1:0] stop_ticks_o
);
  localparam int HALF = TICKS_PER_BIT / 2;

  assign cfg_o.wlen     = lcr_i[1:0];
  assign cfg_o.stop_x   = lcr_i[2];
  assign cfg_o.par_en   = lcr_i[3];
  assign cfg_o.par_even = lcr_i[4];
  assign cfg_o.par_fix  = lcr_i[5];

  always_comb begin
    if (!lcr_i[2])              stop_ticks_o = LIM_W'(TICKS_PER_BIT);
    else if (lcr_i[1:0] == 2'b00) stop_ticks_o = LIM_W'(TICKS_PER_BIT + HALF);
    else                          stop_ticks_o = LIM_W'(2 * TICKS_PER_BIT);
  end
endmodule

// File: rtl/sctx_par_gen.sv
module sctx_par_gen
  import sctx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  sctx_cfg_t         cfg_i,
  output logic              par_o
);
  localparam int MIN_BITS = DATA_W - 3;
  logic [DATA_W-1:0] masked;
  int unsigned nbits;

  assign nbits = MIN_BITS + int'(cfg_i.wlen);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data_i[i] & (i < nbits);
  end

  always_comb begin
    if (cfg_i.par_fix) par_o = ~cfg_i.par_even;
    else               par_o = (^masked) ^ ~cfg_i.par_even;
  end
endmodule

// File: rtl/sctx_bit_timer.sv
module sctx_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT),
  localparam int LIM_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && ({1'b0, cnt_q} == limit_i - LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sctx_top.sv
module sctx_top
  import sctx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic [7:0]        lcr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              dlab_o
);
  localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT);
  localparam int LIM_W    = CNT_W + 1;
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  sctx_state_e       state_q;
  sctx_cfg_t         cfg_d, cfg_q;
  logic [LIM_W-1:0]  stop_d, stop_q, limit;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              par_d, par_q, done, accept, line;

  sctx_cfg_dec #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_dec (
    .lcr_i(lcr_i), .cfg_o(cfg_d), .stop_ticks_o(stop_d)
  );

  sctx_par_gen #(.DATA_W(DATA_W)) u_par (
    .data_i(data_i), .cfg_i(cfg_d), .par_o(par_d)
  );

  assign limit = (state_q == ST_STOP) ? stop_q : LIM_W'(TICKS_PER_BIT);

  sctx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q == ST_IDLE),
    .tick_i(tick16_i), .limit_i(limit), .done_o(done)
  );

  assign ready_o  = (state_q == ST_IDLE);
  assign accept   = valid_i && ready_o;
  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.wlen);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      stop_q  <= LIM_W'(TICKS_PER_BIT);
      sh_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_START;
          cfg_q   <= cfg_d;
          stop_q  <= stop_d;
          sh_q    <= data_i;
          par_q   <= par_d;
        end
        ST_START: if (done) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (done) begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR:  if (done) state_q <= ST_STOP;
        ST_STOP: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  // break overrides the line but not the timing
  assign tx_o   = line & ~lcr_i[6];
  assign dlab_o = lcr_i[7];
endmodule

// File: rtl/sctx_checker.sv
module sctx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick16_i,
  input logic [7:0] lcr_i,
  input logic       valid_i,
  input logic       ready_o,
  input logic       tx_o
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !lcr_i[6]) |-> tx_o); // R1

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !tick16_i) |=> (!tx_o || lcr_i[6])); // R3

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o); // R9

  AST_NO_TICK_NO_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick16_i && !ready_o) |=> !ready_o); // R12

  AST_NO_TICK_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick16_i && !ready_o) |=> (!$stable(lcr_i[6]) || $stable(tx_o))); // R12

  AST_BREAK_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcr_i[6] && !ready_o) |-> !tx_o); // R8
endmodule

bind sctx_top sctx_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .lcr_i(lcr_i),
  .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o)
);

// File: tb/sctx_tb.sv
module sctx_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b1;
  logic [7:0] lcr_i = 8'h00;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       ready_o, tx_o, dlab_o;

  int n_run = 0, n_fail = 0;
  bit ended = 0;

  always #10 clk_i = ~clk_i;

  sctx_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .lcr_i(lcr_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o),
    .dlab_o(dlab_o)
  );

  // {lcr, data}
  localparam logic [15:0] VEC [11] = '{
    16'h00A5, 16'h013C, 16'h027E, 16'h0396, 16'h0413, 16'h075A,
    16'h0B81, 16'h1B81, 16'h3BFF, 16'h2A00, 16'h1A07
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send one character; lcr_mid applied after acceptance
  task automatic run_frame(input logic [7:0] lcr, input logic [7:0] data,
                           input logic [7:0] lcr_mid, input string req);
    int nb, nslot, stopt, total, errs, rdy_err;
    logic [10:0] slot;
    logic brk;
    nb    = 5 + int'(lcr[1:0]);
    stopt = !lcr[2] ? 16 : (nb == 5 ? 24 : 32);
    slot  = '0;
    for (int j = 0; j < nb; j++) slot[1 + j] = data[j];
    nslot = 1 + nb;
    if (lcr[3]) begin
      if (lcr[5]) slot[nslot] = ~lcr[4];
      else begin
        logic x;
        x = 1'b0;
        for (int j = 0; j < nb; j++) x ^= data[j];
        slot[nslot] = x ^ ~lcr[4];
      end
      nslot++;
    end
    total = 16 * nslot + stopt;
    brk   = lcr_mid[6];
    errs = 0; rdy_err = 0;
    @(negedge clk_i);
    lcr_i = lcr; data_i = data; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0; lcr_i = lcr_mid;
    for (int p = 0; p <= total; p++) begin
      if (p > 0) @(negedge clk_i);
      if (p % 16 == 8 && p / 16 < nslot)
        if (tx_o !== (brk ? 1'b0 : slot[p / 16])) errs++;
      if (p == 16 * nslot + 4 && tx_o !== ~brk) errs++;
      if (p < total && ready_o !== 1'b0) rdy_err++;
      if (p == total && (ready_o !== 1'b1 || tx_o !== ~brk)) rdy_err++;
    end
    chk(errs == 0, {req, " bits"}, errs, 0);
    chk(rdy_err == 0, {req, " length R9"}, rdy_err, 0);
    lcr_i = 8'h00;
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ready_o === 1'b1 && tx_o === 1'b1, "R1 reset", {ready_o, tx_o}, 2'b11);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o === 1'b1 && tx_o === 1'b1 && dlab_o === 1'b0, "R1 idle",
        {ready_o, tx_o, dlab_o}, 3'b110);

    // vector table: R2 R3 R4 R5 R6 R7
    foreach (VEC[i]) run_frame(VEC[i][15:8], VEC[i][7:0], VEC[i][15:8],
                               $sformatf("R2/R3/R4/R5/R6/R7 vec%0d", i));

    // R10: change framing mid-character
    run_frame(8'h00, 8'hFF, 8'h3F, "R10 mid change 5b");
    run_frame(8'h1F, 8'h6D, 8'h00, "R10 mid change 8b");

    // R8: break idle, break during frame
    @(negedge clk_i); lcr_i = 8'h40;
    @(negedge clk_i);
    chk(tx_o === 1'b0 && ready_o === 1'b1, "R8 idle break", {tx_o, ready_o}, 2'b01);
    lcr_i = 8'h00;
    @(negedge clk_i);
    chk(tx_o === 1'b1, "R8 break release", tx_o, 1);
    run_frame(8'h03, 8'hFF, 8'h40, "R8 break in frame");

    // R11
    lcr_i = 8'h80; #1;
    chk(dlab_o === 1'b1, "R11 dlab set", dlab_o, 1);
    lcr_i = 8'h7F; #1;
    chk(dlab_o === 1'b0, "R11 dlab clear", dlab_o, 0);
    lcr_i = 8'h00;

    // R12: hold without ticks
    @(negedge clk_i);
    tick16_i = 1'b0; data_i = 8'h00; valid_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(tx_o === 1'b0 && ready_o === 1'b0, "R12 held in start", {tx_o, ready_o}, 2'b00);
    tick16_i = 1'b1;
    repeat (16 * 6 + 16 + 2) @(negedge clk_i);
    chk(ready_o === 1'b1 && tx_o === 1'b1, "R12 resumed", {ready_o, tx_o}, 2'b11);

    // R9: valid held during busy is not taken
    @(negedge clk_i);
    data_i = 8'h00; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(ready_o === 1'b0, "R9 busy", ready_o, 0);
    valid_i = 1'b0;
    repeat (16 * 6 + 16) @(negedge clk_i);
    chk(ready_o === 1'b1, "R9 single accept", ready_o, 1);

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule